// File: doc/BRIEF.md
# Conversion and Interrupt Poll Monitor

This block watches the serial data-out line of a daisy chain of battery measurement devices while the host keeps chip select low after sending either a start-conversion command or an interrupt-poll command. The host gives a one-cycle start pulse and a mode bit. The monitor then turns the line's behaviour into three flags: conversion complete, interrupt pending and conversion timeout.

In toggle mode the chain holds the line low while its conversions run, which takes about 12 ms. Once every device has finished, the line toggles with a period of about 1 ms, so there is an edge about every 500 µs. The monitor declares completion only when two successive clean edges are spaced within a quarter of that nominal half period. It raises a timeout if no such pair appears within a set number of cycles after start. In level mode a low line means that at least one device in the chain reports an interrupt condition. The monitor reflects this on its interrupt output for as long as polling lasts. When the host raises chip select, polling ends and the monitor returns to idle.

The raw line passes through a two-flop synchroniser and a debounce filter before any edge or level is used. All times are parameters in clock cycles.

Top module: `conv_poll_monitor`

## Requirements
- R1: While reset is asserted and immediately after it is released, done_o, irq_o and timeout_o are 0.
- R2: The line passes through two synchroniser flops, and the filtered level changes only after the synchronised value has differed from it for DEB_LEN consecutive cycles. A low or high pulse shorter than DEB_LEN cycles produces no edge and cannot complete a conversion poll.
- R3: In toggle mode (mode_i = 0), done_o rises one cycle after a filtered edge whose spacing from the previous filtered edge since start is between GAP_NOM - GAP_NOM/4 and GAP_NOM + GAP_NOM/4 cycles, inclusive.
- R4: An edge whose spacing falls outside that window does not complete the poll, and that edge becomes the reference for the next spacing. The first edge after start only arms the measurement.
- R5: In toggle mode, timeout_o rises when TMO_CYC cycles pass in the waiting state without a valid edge pair.
- R6: In level mode (mode_i = 1), irq_o equals the inverse of the filtered line, registered one cycle later, so a low line gives 1. done_o and timeout_o stay 0 in this mode.
- R7: Whenever cs_n is 1, the monitor returns to idle on the next clock and all three outputs are 0, which cancels any poll in progress.
- R8: start_i is accepted only in idle with cs_n at 0. A start given during a poll or with cs_n at 1 is ignored and does not restart the timeout count.
- R9: done_o and timeout_o are never 1 together, and each holds until cs_n goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, low while polling |
| sdo_i | input | 1 | Raw serial data-out line from the chain |
| mode_i | input | 1 | 0 = toggle poll for conversions, 1 = level poll for interrupts |
| start_i | input | 1 | One-cycle pulse that starts a poll |
| done_o | output | 1 | Conversions complete (toggle mode) |
| irq_o | output | 1 | Interrupt pending (level mode) |
| timeout_o | output | 1 | No valid toggling within the limit (toggle mode) |

## Verification
The hardest case to reach is a stream of edges that rejects the poll several times over and then completes it. That requires too-short spacings, too-long spacings and sub-debounce glitches, with each rejected edge becoming the new reference. The stimulus gets there by driving toggle trains of 20, then 60, then 40 cycles of spacing in one poll, and by running a separate poll with two-cycle glitches that must end in timeout. A behavioural model in the bench follows every clock, so the exact cycles at which done and timeout rise are compared as well as their final values.

// File: rtl/pollmon_pkg.sv
package pollmon_pkg;

  typedef enum logic [2:0] {
    PM_IDLE   = 3'd0,
    PM_TWAIT  = 3'd1,
    PM_TDONE  = 3'd2,
    PM_TEXP   = 3'd3,
    PM_LSENSE = 3'd4
  } pm_state_e;

  typedef enum logic {
    PM_MODE_TOGGLE = 1'b0,
    PM_MODE_LEVEL  = 1'b1
  } pm_mode_e;

endpackage

// File: rtl/pm_sync_filter.sv
module pm_sync_filter #(
  parameter int DEB_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic lvl_o
);

  localparam int DEB_W = (DEB_LEN > 1) ? $clog2(DEB_LEN + 1) : 1;

  logic sync1_q, sync2_q;

  // Two-flop synchroniser; the line idles high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
    end
  end

  generate
    if (DEB_LEN <= 1) begin : g_nofilt
      assign lvl_o = sync2_q;
    end else begin : g_filt
      localparam logic [DEB_W-1:0] LAST = DEB_W'(DEB_LEN - 1);
      logic             filt_q, filt_d;
      logic [DEB_W-1:0] run_q, run_d;
      logic             run_en;

      always_comb begin
        filt_d = filt_q;
        run_d  = run_q;
        run_en = 1'b1;
        if (sync2_q == filt_q) begin
          run_d  = '0;
          run_en = (run_q != '0);
        end else if (run_q == LAST) begin
          filt_d = sync2_q;
          run_d  = '0;
        end else begin
          run_d  = run_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          filt_q <= 1'b1;
          run_q  <= '0;
        end else if (run_en) begin
          filt_q <= filt_d;
          run_q  <= run_d;
        end
      end

      assign lvl_o = filt_q;

      // R2: a filtered change always takes the synchroniser's earlier value
      a_r2_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(sync2_q) == filt_q));
    end
  endgenerate

endmodule

// File: rtl/pm_gap_timer.sv
module pm_gap_timer #(
  parameter int GAP_LO = 75000,
  parameter int GAP_HI = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic lvl_i,
  output logic pair_ok_o
);

  localparam int GAP_W = $clog2(GAP_HI + 2);
  localparam logic [GAP_W-1:0] LO_V  = GAP_W'(GAP_LO);
  localparam logic [GAP_W-1:0] HI_V  = GAP_W'(GAP_HI);
  localparam logic [GAP_W-1:0] ONE_V = GAP_W'(1);

  logic             prev_q;
  logic             armed_q, armed_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             edge_w;

  assign edge_w    = (lvl_i != prev_q);
  assign pair_ok_o = edge_w && armed_q && (gap_q >= LO_V) && (gap_q <= HI_V);

  always_comb begin
    armed_d = armed_q;
    gap_d   = gap_q;
    if (restart_i) begin
      armed_d = 1'b0;
      gap_d   = '0;
    end else if (edge_w) begin
      armed_d = 1'b1;
      gap_d   = ONE_V;
    end else if (armed_q && (gap_q <= HI_V)) begin
      gap_d   = gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      armed_q <= 1'b0;
      gap_q   <= '0;
    end else begin
      prev_q  <= lvl_i;
      armed_q <= armed_d;
      gap_q   <= gap_d;
    end
  end

  // R4: a qualifying pair needs an armed reference edge seen before
  a_r4_pair_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ok_o |-> $past(armed_q || edge_w));

  // R4: the spacing counter saturates just past the window
  a_r4_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= HI_V + 1'b1);

endmodule

// File: rtl/pm_tmo_counter.sv
module pm_tmo_counter #(
  parameter int TMO_CYC = 4000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);

  localparam int TMO_W = $clog2(TMO_CYC + 1);
  localparam logic [TMO_W-1:0] LAST = TMO_W'(TMO_CYC - 1);

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expire_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clear_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (run_i && (cnt_q != LAST)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5: the wait counter never passes the limit
  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/conv_poll_monitor.sv
module conv_poll_monitor
  import pollmon_pkg::*;
#(
  parameter int DEB_LEN = 16,
  parameter int GAP_NOM = 100000,
  parameter int TMO_CYC = 4000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sdo_i,
  input  logic mode_i,
  input  logic start_i,
  output logic done_o,
  output logic irq_o,
  output logic timeout_o
);

  localparam int GAP_LO = GAP_NOM - GAP_NOM / 4;
  localparam int GAP_HI = GAP_NOM + GAP_NOM / 4;

  pm_state_e state_q, state_d;
  logic      irq_q, irq_d;
  logic      lvl_w, pair_ok_w, expire_w, accept_w;

  pm_sync_filter #(.DEB_LEN(DEB_LEN)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (sdo_i),
    .lvl_o (lvl_w)
  );

  pm_gap_timer #(.GAP_LO(GAP_LO), .GAP_HI(GAP_HI)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (accept_w),
    .lvl_i     (lvl_w),
    .pair_ok_o (pair_ok_w)
  );

  pm_tmo_counter #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (accept_w),
    .run_i    (state_q == PM_TWAIT),
    .expire_o (expire_w)
  );

  assign accept_w = (state_q == PM_IDLE) && !cs_n && start_i;

  always_comb begin
    state_d = state_q;
    irq_d   = irq_q;
    if (cs_n) begin
      state_d = PM_IDLE;
      irq_d   = 1'b0;
    end else begin
      unique case (state_q)
        PM_IDLE: begin
          irq_d = 1'b0;
          if (start_i)
            state_d = (pm_mode_e'(mode_i) == PM_MODE_LEVEL) ? PM_LSENSE : PM_TWAIT;
        end
        PM_TWAIT: begin
          if (pair_ok_w)     state_d = PM_TDONE;
          else if (expire_w) state_d = PM_TEXP;
        end
        PM_LSENSE: irq_d = !lvl_w;
        PM_TDONE, PM_TEXP: state_d = state_q;
        default: state_d = PM_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  assign done_o    = (state_q == PM_TDONE);
  assign timeout_o = (state_q == PM_TEXP);
  assign irq_o     = irq_q;

  // R9: completion and timeout exclude each other
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));

  // R9: done holds while chip select stays low
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cs_n) |=> done_o);

  // R9: timeout holds while chip select stays low
  a_r9_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !cs_n) |=> timeout_o);

  // R7: raising chip select clears every flag on the next clock
  a_r7_cs_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!done_o && !irq_o && !timeout_o));

  // R6: interrupt output is only ever set by a level poll
  a_r6_irq_level_only: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (state_q == PM_LSENSE));

  // R3: completion can only follow a toggle wait
  a_r3_done_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(state_q) == PM_TWAIT));

endmodule

// File: tb/conv_poll_monitor_test.sv
`timescale 1ns/1ps
module conv_poll_monitor_test;

  localparam int DEB = 4;
  localparam int NOM = 40;
  localparam int LO  = NOM - NOM / 4;
  localparam int HI  = NOM + NOM / 4;
  localparam int TMO = 2000;

  logic clk, rst_n, cs_n, sdo, mode, start;
  logic done, irq, tmo;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;
  string cur_req = "R1";

  conv_poll_monitor #(.DEB_LEN(DEB), .GAP_NOM(NOM), .TMO_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_i(sdo), .mode_i(mode),
    .start_i(start), .done_o(done), .irq_o(irq), .timeout_o(tmo)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural reference: states 0 idle, 1 wait, 2 done, 3 timeout, 4 level
  int m_st, m_tmo, m_gap, m_run;
  bit m_irq, m_armed, m_prv, m_f;
  bit syncq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_tmo = 0; m_gap = 0; m_run = 0;
      m_irq = 0; m_armed = 0; m_prv = 1; m_f = 1;
      syncq = {1'b1, 1'b1};
    end else begin
      bit edge_m, pair_m, exp_m, acc_m, s2;
      int nst;
      bit nirq;
      s2 = syncq[0];
      edge_m = (m_f != m_prv);
      pair_m = edge_m && m_armed && (m_gap >= LO) && (m_gap <= HI);
      exp_m  = (m_st == 1) && (m_tmo == TMO - 1);
      acc_m  = (m_st == 0) && !cs_n && start;
      nst = m_st; nirq = m_irq;
      if (cs_n) begin nst = 0; nirq = 0; end
      else if (m_st == 0) begin nirq = 0; if (start) nst = mode ? 4 : 1; end
      else if (m_st == 1) begin if (pair_m) nst = 2; else if (exp_m) nst = 3; end
      else if (m_st == 4) nirq = !m_f;
      if (acc_m) m_tmo = 0;
      else if (m_st == 1 && m_tmo != TMO - 1) m_tmo++;
      if (acc_m) begin m_armed = 0; m_gap = 0; end
      else if (edge_m) begin m_armed = 1; m_gap = 1; end
      else if (m_armed && m_gap <= HI) m_gap++;
      m_prv = m_f;
      if (s2 == m_f) m_run = 0;
      else if (m_run == DEB - 1) begin m_f = s2; m_run = 0; end
      else m_run++;
      void'(syncq.pop_front());
      syncq.push_back(sdo);
      m_st = nst; m_irq = nirq;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-clock comparison with the model, tagged by the scenario's requirement
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !finished) begin
      check(cur_req, "done", done, m_st == 2);
      check(cur_req, "timeout", tmo, m_st == 3);
      check(cur_req, "irq", irq, m_irq);
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    report();
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start(bit md);
    mode = md; start = 1'b1; tick(1); start = 1'b0;
  endtask

  task automatic toggles(int spacing, int count);
    for (int i = 0; i < count; i++) begin sdo = ~sdo; tick(spacing); end
  endtask

  task automatic release_cs();
    cs_n = 1'b1; sdo = 1'b1; tick(20); cs_n = 1'b0; tick(2);
  endtask

  initial begin
    rst_n = 0; cs_n = 1; sdo = 1; mode = 0; start = 0;
    tick(3);
    cur_req = "R1";
    check("R1", "done in reset", done, 0);
    check("R1", "irq in reset", irq, 0);
    check("R1", "timeout in reset", tmo, 0);
    rst_n = 1; tick(2);
    check("R1", "flags after reset", {done, irq, tmo}, 0);
    cs_n = 0; tick(2);

    // R3: low while busy, then a clean 40-cycle toggle train
    cur_req = "R3";
    pulse_start(0); sdo = 0; tick(300);
    check("R3", "done while busy", done, 0);
    toggles(NOM, 4);
    check("R3", "done after valid pair", done, 1);
    check("R9", "done sticky", done, 1);
    release_cs();

    // R2: sub-debounce glitches never complete; poll ends in timeout
    cur_req = "R2";
    pulse_start(0); sdo = 0;
    for (int i = 0; i < 50; i++) begin tick(38); sdo = 1; tick(2); sdo = 0; end
    tick(200);
    check("R2", "done after glitches", done, 0);
    check("R5", "timeout after glitches", tmo, 1);
    release_cs();

    // R4: too short, then too long, then valid spacing
    cur_req = "R4";
    pulse_start(0); sdo = 0; tick(100);
    toggles(20, 20);
    check("R4", "done after short spacing", done, 0);
    toggles(60, 6);
    check("R4", "done after long spacing", done, 0);
    toggles(NOM, 2);
    check("R4", "done after valid pair", done, 1);
    release_cs();

    // R5: line stays low; exact expiry cycle compared each clock
    cur_req = "R5";
    pulse_start(0); sdo = 0; tick(TMO - 10);
    check("R5", "timeout early", tmo, 0);
    tick(20);
    check("R5", "timeout at limit", tmo, 1);
    tick(100);
    check("R9", "timeout sticky", tmo, 1);
    check("R9", "done with timeout", done, 0);
    release_cs();

    // R8: second start in a poll does not restart the wait
    cur_req = "R8";
    pulse_start(0); sdo = 0; tick(1000);
    pulse_start(0); tick(TMO - 1000 + 10);
    check("R8", "timeout from first start", tmo, 1);
    release_cs();

    // R8: start with chip select high is ignored
    cs_n = 1; pulse_start(0); tick(3); cs_n = 0; sdo = 0; tick(100);
    toggles(NOM, 4);
    check("R8", "done without accepted start", done, 0);
    check("R8", "timeout without accepted start", tmo, 0);
    release_cs();

    // R6: level poll follows the line
    cur_req = "R6";
    pulse_start(1); tick(20);
    check("R6", "irq line high", irq, 0);
    sdo = 0; tick(20);
    check("R6", "irq line low", irq, 1);
    sdo = 1; tick(20);
    check("R6", "irq line high again", irq, 0);
    sdo = 0; toggles(NOM, 4); tick(TMO);
    check("R6", "done in level mode", done, 0);
    check("R6", "timeout in level mode", tmo, 0);

    // R7: chip select high cancels and clears
    cur_req = "R7";
    cs_n = 1; tick(2);
    check("R7", "irq cleared", irq, 0);
    cs_n = 0; tick(2);
    pulse_start(0); sdo = 0; tick(200);
    cs_n = 1; tick(2);
    check("R7", "flags after cancel", {done, irq, tmo}, 0);
    cs_n = 0; toggles(NOM, 4);
    check("R7", "no done after cancel", done, 0);
    sdo = 1; tick(5);
    report();
  end

endmodule